// File: doc/BRIEF.md
# Dual-Section Registered Bus Transceiver

The block moves bytes between an A bus and a B bus. It is split into independent sections, two by default, each `WIDTH` bits wide. Each section can pass data in either direction. On the driven side it delivers either the live value from the opposite bus or a copy held in a storage register. Each bus has its own storage register, loaded by its own capture strobe. A byte can therefore be parked from either bus, or from both at once, and sent out later.

Bus pads appear as separate input, output and output-enable signals, so the block fits inside a core next to the real pad cells. The capture strobes are ordinary inputs sampled on the system clock. A register loads on the first clock edge at which its strobe is seen high after having been seen low. An active-low output enable per section overrides the direction bit and releases both buses.

Top module: `dual_reg_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears every storage register to zero. While reset is held, each strobe's previous-sample state follows the strobe, so a strobe that is already high when reset ends does not cause a load.
- R2: The A-side register of a section loads that section's `a_in` byte at the clock edge where `cap_a` is sampled 1, provided the previous sample was 0. Otherwise it holds its value.
- R3: The B-side register of a section loads `b_in` on a 0-to-1 transition of `cap_b`, detected the same way. Otherwise it holds its value.
- R4: Both registers of a section can load in the same clock edge, and each takes only its own bus.
- R5: When `b_oe` is 1, `b_out` equals live `a_in` if `sel_ab` is 0, and the stored A register if `sel_ab` is 1. The value appears in the same cycle, with no register on the path.
- R6: When `a_oe` is 1, `a_out` equals live `b_in` if `sel_ba` is 0, and the stored B register if `sel_ba` is 1. The value appears in the same cycle.
- R7: With `oe_n` at 0, `dir` at 1 sets `b_oe` (A drives B) and `dir` at 0 sets `a_oe` (B drives A). Exactly one of the two is 1.
- R8: With `oe_n` at 1, both `a_oe` and `b_oe` of that section are 0, whatever `dir` is.
- R9: Loading continues while `oe_n` is 1. A byte captured with the buses released is visible once the outputs are enabled again.
- R10: A strobe held high loads only once. Later changes to the bus do not reach the register until the strobe has been seen low and then high again.
- R11: The sections are independent. Controls and strobes of one section change neither the registers nor the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the capture strobes |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | SECTIONS | Per-section output enable, active low |
| dir | input | SECTIONS | Per-section direction, 1 = A to B |
| sel_ab | input | SECTIONS | 1 = B bus gets stored A byte, 0 = live A |
| sel_ba | input | SECTIONS | 1 = A bus gets stored B byte, 0 = live B |
| cap_a | input | SECTIONS | Capture strobe of the A-side register |
| cap_b | input | SECTIONS | Capture strobe of the B-side register |
| a_in | input | SECTIONS*WIDTH | Value seen on the A pads |
| a_out | output | SECTIONS*WIDTH | Value to drive on the A pads |
| a_oe | output | SECTIONS | A pad drive enable per section |
| b_in | input | SECTIONS*WIDTH | Value seen on the B pads |
| b_out | output | SECTIONS*WIDTH | Value to drive on the B pads |
| b_oe | output | SECTIONS | B pad drive enable per section |

## Verification
The properties assume that the strobes, selects and buses are synchronous to `clk`, so that a strobe level seen at one edge is the level the edge detector also sees. The stored-path stability check also assumes that a strobe held high for two samples is one long pulse, not two pulses merged. The bench changes every input only on the falling clock edge. It raises each strobe for a known number of cycles and lowers it again before the next load. It reads the bus outputs only while the matching enable is on, because their value is unspecified otherwise.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Source picked for a driven bus.
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  // Which port a section drives.
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;

  function automatic drive_e drive_of(input logic oe_n, input logic dir);
    if (oe_n) return DRV_NONE;
    return dir ? DRV_B : DRV_A;
  endfunction
endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic strobe_q;
  logic load;

  assign load = strobe && !strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= '0;
      strobe_q <= strobe;
    end else begin
      strobe_q <= strobe;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_live,
  input  logic [WIDTH-1:0] b_live,
  input  logic [WIDTH-1:0] a_held,
  input  logic [WIDTH-1:0] b_held,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] b_out,
  output logic             a_oe,
  output logic             b_oe
);
  drive_e drv;
  src_e   src_to_b;
  src_e   src_to_a;

  always_comb begin
    drv      = drive_of(oe_n, dir);
    src_to_b = sel_ab ? SRC_STORED : SRC_LIVE;
    src_to_a = sel_ba ? SRC_STORED : SRC_LIVE;
    a_oe     = (drv == DRV_A);
    b_oe     = (drv == DRV_B);
    b_out    = (src_to_b == SRC_STORED) ? a_held : a_live;
    a_out    = (src_to_a == SRC_STORED) ? b_held : b_live;
  end
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             cap_a,
  input  logic             cap_b,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] b_out,
  output logic             a_oe,
  output logic             b_oe
);
  logic [WIDTH-1:0] a_held;
  logic [WIDTH-1:0] b_held;

  xcvr_capture #(.WIDTH(WIDTH)) a_reg_i (
    .clk(clk), .rst(rst), .strobe(cap_a), .d(a_in), .q(a_held)
  );

  xcvr_capture #(.WIDTH(WIDTH)) b_reg_i (
    .clk(clk), .rst(rst), .strobe(cap_b), .d(b_in), .q(b_held)
  );

  xcvr_route #(.WIDTH(WIDTH)) route_i (
    .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_live(a_in), .b_live(b_in), .a_held(a_held), .b_held(b_held),
    .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe)
  );
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [SECTIONS-1:0]       oe_n,
  input  logic [SECTIONS-1:0]       dir,
  input  logic [SECTIONS-1:0]       sel_ab,
  input  logic [SECTIONS-1:0]       sel_ba,
  input  logic [SECTIONS-1:0]       cap_a,
  input  logic [SECTIONS-1:0]       cap_b,
  input  logic [SECTIONS*WIDTH-1:0] a_in,
  output logic [SECTIONS*WIDTH-1:0] a_out,
  output logic [SECTIONS-1:0]       a_oe,
  input  logic [SECTIONS*WIDTH-1:0] b_in,
  output logic [SECTIONS*WIDTH-1:0] b_out,
  output logic [SECTIONS-1:0]       b_oe
);
  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    xcvr_section #(.WIDTH(WIDTH)) sec_i (
      .clk   (clk),
      .rst   (rst),
      .oe_n  (oe_n[s]),
      .dir   (dir[s]),
      .sel_ab(sel_ab[s]),
      .sel_ba(sel_ba[s]),
      .cap_a (cap_a[s]),
      .cap_b (cap_b[s]),
      .a_in  (a_in[s*WIDTH +: WIDTH]),
      .b_in  (b_in[s*WIDTH +: WIDTH]),
      .a_out (a_out[s*WIDTH +: WIDTH]),
      .b_out (b_out[s*WIDTH +: WIDTH]),
      .a_oe  (a_oe[s]),
      .b_oe  (b_oe[s])
    );
  end
endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [SECTIONS-1:0]       oe_n,
  input logic [SECTIONS-1:0]       dir,
  input logic [SECTIONS-1:0]       sel_ab,
  input logic [SECTIONS-1:0]       sel_ba,
  input logic [SECTIONS-1:0]       cap_a,
  input logic [SECTIONS*WIDTH-1:0] a_in,
  input logic [SECTIONS*WIDTH-1:0] a_out,
  input logic [SECTIONS-1:0]       a_oe,
  input logic [SECTIONS*WIDTH-1:0] b_in,
  input logic [SECTIONS*WIDTH-1:0] b_out,
  input logic [SECTIONS-1:0]       b_oe
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  for (genvar s = 0; s < SECTIONS; s++) begin : g_chk
    // R8
    released_chk: assert property (@(posedge clk) disable iff (rst)
      oe_n[s] |-> (!a_oe[s] && !b_oe[s]));
    // R7
    one_driver_chk: assert property (@(posedge clk) disable iff (rst)
      !oe_n[s] |-> ($countones({a_oe[s], b_oe[s]}) == 1 && b_oe[s] == dir[s]));
    // R5
    live_to_b_chk: assert property (@(posedge clk) disable iff (rst)
      (b_oe[s] && !sel_ab[s]) |-> b_out[s*WIDTH +: WIDTH] == a_in[s*WIDTH +: WIDTH]);
    // R6
    live_to_a_chk: assert property (@(posedge clk) disable iff (rst)
      (a_oe[s] && !sel_ba[s]) |-> a_out[s*WIDTH +: WIDTH] == b_in[s*WIDTH +: WIDTH]);
    // R10
    held_level_chk: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3 && sel_ab[s] && $past(sel_ab[s])
       && $past(cap_a[s], 2) && $past(cap_a[s]))
      |-> $stable(b_out[s*WIDTH +: WIDTH]));
  end
endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.SECTIONS(SECTIONS), .WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .cap_a(cap_a), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/dual_reg_xcvr_tb_top.sv
`timescale 1ns/1ps
module dual_reg_xcvr_tb_top;
  localparam int S = 2;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [S-1:0]   oe_n = '1, dir = '0, sel_ab = '0, sel_ba = '0, cap_a = '0, cap_b = '0;
  logic [S*W-1:0] a_in = '0, b_in = '0;
  logic [S*W-1:0] a_out, b_out;
  logic [S-1:0]   a_oe, b_oe;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dual_reg_xcvr #(.SECTIONS(S), .WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .cap_a(cap_a), .cap_b(cap_b), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One pulse on a strobe: high for one sample, then low.
  task automatic pulse(input bit is_a, input int s);
    if (is_a) cap_a[s] = 1'b1; else cap_b[s] = 1'b1;
    cyc(1);
    if (is_a) cap_a[s] = 1'b0; else cap_b[s] = 1'b0;
    cyc(1);
  endtask

  // Read stored A of section s through B bus.
  task automatic read_a(input int s, output logic [W-1:0] v);
    oe_n[s] = 1'b0; dir[s] = 1'b1; sel_ab[s] = 1'b1;
    #1 v = b_out[s*W +: W];
  endtask

  task automatic read_b(input int s, output logic [W-1:0] v);
    oe_n[s] = 1'b0; dir[s] = 1'b0; sel_ba[s] = 1'b1;
    #1 v = a_out[s*W +: W];
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    a_in = 16'hA5C3; b_in = 16'h3C5A;
    cap_a = '1; cap_b = '1;          // strobes high across reset
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(2);
    for (int s = 0; s < S; s++) begin
      read_a(s, v); check("R1 A reg after reset", v, 0);
      read_b(s, v); check("R1 B reg after reset", v, 0);
    end
    cap_a = '0; cap_b = '0; cyc(1);
  endtask

  task automatic t_enables();
    oe_n = '0; dir = 2'b01; #1;
    check("R7 dir pattern 01 a_oe", a_oe, 2'b10);
    check("R7 dir pattern 01 b_oe", b_oe, 2'b01);
    dir = 2'b10; #1;
    check("R7 dir pattern 10 a_oe", a_oe, 2'b01);
    check("R7 dir pattern 10 b_oe", b_oe, 2'b10);
    oe_n = '1; dir = 2'b11; #1;
    check("R8 released enables", {a_oe, b_oe}, 0);
    dir = 2'b00; #1;
    check("R8 released enables dir0", {a_oe, b_oe}, 0);
    cyc(1);
  endtask

  task automatic t_live();
    oe_n = '0; sel_ab = '0; sel_ba = '0;
    dir = '1; a_in = 16'h1234; #1;
    check("R5 live A to B", b_out, 16'h1234);
    a_in = 16'hFE01; #1;
    check("R5 live A follows input", b_out, 16'hFE01);
    dir = '0; b_in = 16'h7788; #1;
    check("R6 live B to A", a_out, 16'h7788);
    cyc(1);
  endtask

  task automatic t_cap_a();
    logic [W-1:0] v;
    a_in[7:0] = 8'h5E; pulse(1, 0);
    a_in[7:0] = 8'h00;
    read_a(0, v); check("R2 A reg loaded", v, 8'h5E);
    check("R5 stored A on B bus", b_out[7:0], 8'h5E);
    cyc(2); read_a(0, v); check("R2 A reg holds", v, 8'h5E);
    cyc(1);
  endtask

  task automatic t_cap_b();
    logic [W-1:0] v;
    b_in[7:0] = 8'hC7; pulse(0, 0);
    b_in[7:0] = 8'h11;
    read_b(0, v); check("R3 B reg loaded", v, 8'hC7);
    check("R6 stored B on A bus", a_out[7:0], 8'hC7);
    cyc(1);
  endtask

  task automatic t_both();
    logic [W-1:0] v;
    a_in[15:8] = 8'h9A; b_in[15:8] = 8'h4B;
    cap_a[1] = 1'b1; cap_b[1] = 1'b1; cyc(1);
    cap_a[1] = 1'b0; cap_b[1] = 1'b0; a_in[15:8] = 8'h00; b_in[15:8] = 8'h00; cyc(1);
    read_a(1, v); check("R4 same-edge A load", v, 8'h9A);
    read_b(1, v); check("R4 same-edge B load", v, 8'h4B);
    cyc(1);
  endtask

  task automatic t_off_capture();
    logic [W-1:0] v;
    oe_n[0] = 1'b1; #1;
    check("R9 bus released", {a_oe[0], b_oe[0]}, 0);
    a_in[7:0] = 8'h3D; pulse(1, 0);
    check("R9 still released", {a_oe[0], b_oe[0]}, 0);
    read_a(0, v); check("R9 load while released", v, 8'h3D);
    cyc(1);
  endtask

  task automatic t_level();
    logic [W-1:0] v;
    a_in[7:0] = 8'h66; cap_a[0] = 1'b1; cyc(1);
    a_in[7:0] = 8'h99; cyc(3);
    read_a(0, v); check("R10 level holds first value", v, 8'h66);
    cap_a[0] = 1'b0; cyc(1); cap_a[0] = 1'b1; cyc(1); cap_a[0] = 1'b0; cyc(1);
    read_a(0, v); check("R10 new pulse loads", v, 8'h99);
    cyc(1);
  endtask

  task automatic t_sections();
    logic [W-1:0] v;
    logic [W-1:0] before1;
    read_a(1, before1);
    oe_n[1] = 1'b0; dir[1] = 1'b1; sel_ab[1] = 1'b1;
    a_in = 16'h2277; pulse(1, 0);       // only section 0 strobe
    read_a(1, v); check("R11 other section A reg kept", v, before1);
    read_a(0, v); check("R11 own section loaded", v, 8'h77);
    oe_n[0] = 1'b1; dir[0] = 1'b0; #1;
    check("R11 section1 still drives B", b_oe[1], 1'b1);
    check("R11 section1 B data", b_out[15:8], before1);
    cyc(1);
  endtask

  initial begin
    cyc(1);
    t_reset();
    t_enables();
    t_live();
    t_cap_a();
    t_cap_b();
    t_both();
    t_off_capture();
    t_level();
    t_sections();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule